// File: doc/BRIEF.md
# Privilege Mode and Exception Controller

This block keeps track of which privilege level a small processor core is running in and decides what happens when an exception is raised. It knows three levels: user, supervisor and fault. User code is always suspended while an exception is handled. When a trap is taken, the block chooses the new level, the cause code and the handler address, and it records the program counter at which execution should later resume.

Synchronous causes come with the instruction that is executing: a service call, a debug event or an encoding the decoder does not recognise. One asynchronous source exists, a notification from the hardware-management path. That notification is held pending until an instruction boundary at which it may be taken. An exception raised in supervisor code escalates to fault mode as a double fault. A debug event in supervisor code is reported under its own cause and is handled in fault mode. A return instruction goes from supervisor to user and from fault back to supervisor.

The pipeline feeds one executing instruction per cycle with its qualifiers. All outputs are registered: a trap or redirect appears in the cycle after the clock edge that sampled its cause.

Top module: `trap_mode_ctrl`

## Requirements
- R1: After reset the mode output is supervisor, trap and redirect are low, and both saved-PC registers hold 0. The mode encoding is user=0, supervisor=1, fault=2, and the value 3 never appears.
- R2: A synchronous exception taken in user mode enters supervisor mode. The redirect PC is SUP_BASE + (cause << STRIDE_LG) when per-cause vectors are enabled.
- R3: An exception taken in supervisor mode enters fault mode. The redirect PC is FLT_BASE + (cause << STRIDE_LG).
- R4: A debug event reports cause 1 in user mode and cause 2 in supervisor mode.
- R5: The cause codes are service call=0, debug=1, supervisor debug=2, unknown instruction=3 and hardware-management=4. When several synchronous requests arrive together, the order is unknown instruction, then debug, then service call, then return.
- R6: A return executed in supervisor mode enters user mode and redirects to the PC saved on the last entry to supervisor mode. A return executed in fault mode enters supervisor mode and redirects to the PC saved on the last entry to fault mode. Neither raises trap.
- R7: A return executed in user mode raises unknown instruction (cause 3) and enters supervisor mode.
- R8: A synchronous trap reports and saves the PC of the executing instruction. An asynchronous trap reports and saves the next-instruction PC.
- R9: A hardware-management request stays pending until it is taken. It is taken only in a cycle with a valid instruction that raises no synchronous exception and executes no return.
- R10: A pending hardware-management request is not taken while in fault mode. It is taken once the core has left fault mode.
- R11: Trap and redirect are pulses that last one cycle and appear one cycle after the sampled edge. Synchronous request inputs have no effect when instr_valid is low.
- R12: An exception taken in fault mode stays in fault mode, reports the user-mode cause coding (debug=1), and overwrites the fault saved PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction executes this cycle |
| instr_pc | input | PC_W | PC of the executing instruction |
| next_pc | input | PC_W | PC of the instruction that follows |
| svc_req | input | 1 | Service-call instruction |
| dbg_req | input | 1 | Debug event on this instruction |
| unk_req | input | 1 | Unrecognised instruction encoding |
| ret_req | input | 1 | Return-from-handler instruction |
| hwm_req | input | 1 | Hardware-management notification pulse |
| mode_o | output | 2 | Current mode |
| trap_o | output | 1 | Trap taken pulse |
| cause_o | output | 3 | Cause of the last trap |
| epc_o | output | PC_W | Saved PC of the last trap |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | PC_W | Redirect target |

## Verification
The bench builds the block with PC_W=16, STRIDE_LG=3, per-cause vectors enabled, SUP_BASE=0x100 and FLT_BASE=0x200. With these values every cause lands on its own handler address, so a wrong cause or a wrong base can be seen in the redirect PC. The narrow PC keeps the saved-PC values easy to follow through nested entries and returns. These settings also make reachable the double-fault path, the supervisor-debug escalation, and an asynchronous request that waits through fault mode and is taken after the return to supervisor.

// File: rtl/trap_mode_pkg.sv
package trap_mode_pkg;
   typedef enum logic [1:0] {
      MODE_USER = 2'd0,
      MODE_SUP  = 2'd1,
      MODE_FLT  = 2'd2
   } priv_mode_e;

   typedef enum logic [2:0] {
      CS_SVC    = 3'd0,
      CS_DBG    = 3'd1,
      CS_SVCDBG = 3'd2,
      CS_UNK    = 3'd3,
      CS_HWM    = 3'd4
   } trap_cause_e;
endpackage

// File: rtl/trap_async_pend.sv
module trap_async_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic take_i,
   output logic pend_o
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else
         pend_q <= (pend_q | req_i) & ~take_i;
   end

   assign pend_o = pend_q | req_i;
endmodule

// File: rtl/trap_cause_sel.sv
module trap_cause_sel
   import trap_mode_pkg::*;
(
   input  priv_mode_e  mode_i,
   input  logic        valid_i,
   input  logic        svc_i,
   input  logic        dbg_i,
   input  logic        unk_i,
   input  logic        ret_i,
   input  logic        apend_i,
   output logic        take_sync_o,
   output logic        take_async_o,
   output logic        do_ret_o,
   output trap_cause_e cause_o,
   output priv_mode_e  target_o
);
   logic ret_user;
   logic sync_any;

   assign ret_user    = ret_i && (mode_i == MODE_USER);
   assign sync_any    = valid_i && (unk_i || dbg_i || svc_i || ret_user);
   assign take_sync_o = sync_any;
   assign do_ret_o    = valid_i && ret_i && !ret_user && !unk_i && !dbg_i && !svc_i;
   assign take_async_o = apend_i && valid_i && !sync_any && !do_ret_o
                         && (mode_i != MODE_FLT);

   always_comb begin
      if (!sync_any)
         cause_o = CS_HWM;
      else if (unk_i)
         cause_o = CS_UNK;
      else if (dbg_i)
         cause_o = (mode_i == MODE_SUP) ? CS_SVCDBG : CS_DBG;
      else if (svc_i)
         cause_o = CS_SVC;
      else
         cause_o = CS_UNK;
   end

   assign target_o = (mode_i == MODE_USER) ? MODE_SUP : MODE_FLT;
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
   import trap_mode_pkg::*;
#(
   parameter int          PC_W          = 24,
   parameter int          STRIDE_LG     = 4,
   parameter bit          VEC_PER_CAUSE = 1'b1,
   parameter logic [PC_W-1:0] SUP_BASE  = PC_W'(32'h100),
   parameter logic [PC_W-1:0] FLT_BASE  = PC_W'(32'h200)
) (
   input  priv_mode_e      target_i,
   input  trap_cause_e     cause_i,
   output logic [PC_W-1:0] vec_o
);
   logic [PC_W-1:0] base;

   assign base = (target_i == MODE_SUP) ? SUP_BASE : FLT_BASE;

   generate
      if (VEC_PER_CAUSE) begin : g_table
         assign vec_o = base + (PC_W'(cause_i) << STRIDE_LG);
      end else begin : g_single
         logic [2:0] unused_cause;
         assign unused_cause = cause_i;
         assign vec_o = base;
      end
   endgenerate
endmodule

// File: rtl/trap_mode_ctrl.sv
module trap_mode_ctrl
   import trap_mode_pkg::*;
#(
   parameter int          PC_W          = 24,
   parameter int          STRIDE_LG     = 4,
   parameter bit          VEC_PER_CAUSE = 1'b1,
   parameter logic [PC_W-1:0] SUP_BASE  = PC_W'(32'h100),
   parameter logic [PC_W-1:0] FLT_BASE  = PC_W'(32'h200)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_valid,
   input  logic [PC_W-1:0] instr_pc,
   input  logic [PC_W-1:0] next_pc,
   input  logic            svc_req,
   input  logic            dbg_req,
   input  logic            unk_req,
   input  logic            ret_req,
   input  logic            hwm_req,
   output logic [1:0]      mode_o,
   output logic            trap_o,
   output logic [2:0]      cause_o,
   output logic [PC_W-1:0] epc_o,
   output logic            redirect_o,
   output logic [PC_W-1:0] redirect_pc_o
);
   localparam int VEC_SPAN = 3 + STRIDE_LG;

   generate
      if (PC_W < 8) begin : g_chk_pcw
         $error("trap_mode_ctrl: PC_W must be at least 8");
      end
      if (VEC_SPAN >= PC_W) begin : g_chk_span
         $error("trap_mode_ctrl: vector table does not fit in PC_W");
      end
      if ((SUP_BASE & ((PC_W'(1) << VEC_SPAN) - 1'b1)) != '0) begin : g_chk_sup
         $error("trap_mode_ctrl: SUP_BASE must be aligned to the vector table");
      end
      if ((FLT_BASE & ((PC_W'(1) << VEC_SPAN) - 1'b1)) != '0) begin : g_chk_flt
         $error("trap_mode_ctrl: FLT_BASE must be aligned to the vector table");
      end
   endgenerate

   priv_mode_e      mode_q;
   logic [PC_W-1:0] epc_sup_q;
   logic [PC_W-1:0] epc_flt_q;

   logic            apend;
   logic            take_sync;
   logic            take_async;
   logic            do_ret;
   trap_cause_e     sel_cause;
   priv_mode_e      target;
   logic [PC_W-1:0] vec;
   logic [PC_W-1:0] save_pc;
   logic            take_any;

   trap_async_pend u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (hwm_req),
      .take_i (take_async),
      .pend_o (apend)
   );

   trap_cause_sel u_sel (
      .mode_i       (mode_q),
      .valid_i      (instr_valid),
      .svc_i        (svc_req),
      .dbg_i        (dbg_req),
      .unk_i        (unk_req),
      .ret_i        (ret_req),
      .apend_i      (apend),
      .take_sync_o  (take_sync),
      .take_async_o (take_async),
      .do_ret_o     (do_ret),
      .cause_o      (sel_cause),
      .target_o     (target)
   );

   trap_vector_gen #(
      .PC_W          (PC_W),
      .STRIDE_LG     (STRIDE_LG),
      .VEC_PER_CAUSE (VEC_PER_CAUSE),
      .SUP_BASE      (SUP_BASE),
      .FLT_BASE      (FLT_BASE)
   ) u_vec (
      .target_i (target),
      .cause_i  (sel_cause),
      .vec_o    (vec)
   );

   assign take_any = take_sync | take_async;
   assign save_pc  = take_sync ? instr_pc : next_pc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q        <= MODE_SUP;
         epc_sup_q     <= '0;
         epc_flt_q     <= '0;
         trap_o        <= 1'b0;
         cause_o       <= 3'd0;
         epc_o         <= '0;
         redirect_o    <= 1'b0;
         redirect_pc_o <= '0;
      end else if (take_any) begin
         mode_q        <= target;
         trap_o        <= 1'b1;
         cause_o       <= sel_cause;
         epc_o         <= save_pc;
         redirect_o    <= 1'b1;
         redirect_pc_o <= vec;
         if (target == MODE_SUP)
            epc_sup_q <= save_pc;
         else
            epc_flt_q <= save_pc;
      end else if (do_ret) begin
         trap_o     <= 1'b0;
         redirect_o <= 1'b1;
         if (mode_q == MODE_SUP) begin
            mode_q        <= MODE_USER;
            redirect_pc_o <= epc_sup_q;
         end else begin
            mode_q        <= MODE_SUP;
            redirect_pc_o <= epc_flt_q;
         end
      end else begin
         trap_o     <= 1'b0;
         redirect_o <= 1'b0;
      end
   end

   assign mode_o = mode_q;
endmodule

// File: rtl/trap_mode_chk.sv
module trap_mode_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       instr_valid,
   input logic [1:0] mode_o,
   input logic       trap_o,
   input logic [2:0] cause_o,
   input logic       redirect_o
);
   p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o != 2'd3);

   p_user_trap_to_sup_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_o && $past(mode_o) == 2'd0) |-> mode_o == 2'd1);

   p_sup_trap_to_flt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_o && $past(mode_o) != 2'd0) |-> mode_o == 2'd2);

   p_cause_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> cause_o <= 3'd4);

   p_fault_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_o && !trap_o && $past(mode_o) == 2'd2) |-> mode_o == 2'd1);

   p_no_async_in_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_o && cause_o == 3'd4) |-> $past(mode_o) != 2'd2);

   p_trap_redirects_r11: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> redirect_o);

   p_trap_needs_instr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> $past(instr_valid));
endmodule

bind trap_mode_ctrl trap_mode_chk u_trap_mode_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .mode_o      (mode_o),
   .trap_o      (trap_o),
   .cause_o     (cause_o),
   .redirect_o  (redirect_o)
);

// File: tb/test_trap_mode_ctrl.sv
module test_trap_mode_ctrl;
   localparam int PW = 16;

   typedef struct {
      string         tag;
      logic [1:0]    mode;
      logic          trap;
      logic [2:0]    cause;
      logic [PW-1:0] epc;
      logic          redir;
      logic [PW-1:0] rpc;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          instr_valid = 1'b0;
   logic [PW-1:0] instr_pc = '0;
   logic [PW-1:0] next_pc = '0;
   logic          svc_req = 1'b0;
   logic          dbg_req = 1'b0;
   logic          unk_req = 1'b0;
   logic          ret_req = 1'b0;
   logic          hwm_req = 1'b0;
   logic [1:0]    mode_o;
   logic          trap_o;
   logic [2:0]    cause_o;
   logic [PW-1:0] epc_o;
   logic          redirect_o;
   logic [PW-1:0] redirect_pc_o;

   int   n_cmp = 0;
   int   n_bad = 0;
   int   cycles = 0;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   trap_mode_ctrl #(
      .PC_W          (PW),
      .STRIDE_LG     (3),
      .VEC_PER_CAUSE (1'b1),
      .SUP_BASE      (16'h0100),
      .FLT_BASE      (16'h0200)
   ) i_trap_mode_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .instr_valid   (instr_valid),
      .instr_pc      (instr_pc),
      .next_pc       (next_pc),
      .svc_req       (svc_req),
      .dbg_req       (dbg_req),
      .unk_req       (unk_req),
      .ret_req       (ret_req),
      .hwm_req       (hwm_req),
      .mode_o        (mode_o),
      .trap_o        (trap_o),
      .cause_o       (cause_o),
      .epc_o         (epc_o),
      .redirect_o    (redirect_o),
      .redirect_pc_o (redirect_pc_o)
   );

   task automatic check(string tag, string what, longint act, longint expv);
      n_cmp++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // driver: apply one cycle of stimulus and queue the expected result
   task automatic step(string tag, logic v, logic [PW-1:0] pc, logic [PW-1:0] npc,
                       logic s, logic d, logic u, logic r, logic h,
                       logic [1:0] e_mode, logic e_trap, logic [2:0] e_cause,
                       logic [PW-1:0] e_epc, logic e_redir, logic [PW-1:0] e_rpc);
      exp_t e;
      @(negedge clk);
      instr_valid = v; instr_pc = pc; next_pc = npc;
      svc_req = s; dbg_req = d; unk_req = u; ret_req = r; hwm_req = h;
      e.tag = tag; e.mode = e_mode; e.trap = e_trap; e.cause = e_cause;
      e.epc = e_epc; e.redir = e_redir; e.rpc = e_rpc;
      exp_q.push_back(e);
   endtask

   // monitor: compare after each rising edge
   always @(posedge clk) begin
      #2;
      if (exp_q.size() != 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check(e.tag, "mode", mode_o, e.mode);
         check(e.tag, "trap", trap_o, e.trap);
         check(e.tag, "redirect", redirect_o, e.redir);
         if (e.trap) begin
            check(e.tag, "cause", cause_o, e.cause);
            check(e.tag, "epc", epc_o, e.epc);
         end
         if (e.redir)
            check(e.tag, "redirect_pc", redirect_pc_o, e.rpc);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 4000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<=4000", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;
      check("R1", "reset mode", mode_o, 2'd1);
      check("R1", "reset trap", trap_o, 1'b0);
      check("R1", "reset redirect", redirect_o, 1'b0);
      //    tag    v  pc       npc      s d u r h   mode trap cause epc      redir rpc
      step("R11", 0, 16'h0000, 16'h0000, 1,0,0,0,0, 2'd1, 0, 3'd0, 16'h0000, 0, 16'h0000);
      step("R6",  1, 16'h0040, 16'h0044, 0,0,0,1,0, 2'd0, 0, 3'd0, 16'h0000, 1, 16'h0000);
      step("R2",  1, 16'h0050, 16'h0054, 1,0,0,0,0, 2'd1, 1, 3'd0, 16'h0050, 1, 16'h0100);
      step("R11", 0, 16'h0000, 16'h0000, 0,0,0,0,0, 2'd1, 0, 3'd0, 16'h0000, 0, 16'h0000);
      step("R6",  1, 16'h0104, 16'h0108, 0,0,0,1,0, 2'd0, 0, 3'd0, 16'h0000, 1, 16'h0050);
      step("R4",  1, 16'h0060, 16'h0064, 0,1,0,0,0, 2'd1, 1, 3'd1, 16'h0060, 1, 16'h0108);
      step("R3",  1, 16'h0110, 16'h0114, 0,1,0,0,0, 2'd2, 1, 3'd2, 16'h0110, 1, 16'h0210);
      step("R12", 1, 16'h0214, 16'h0218, 1,0,0,0,0, 2'd2, 1, 3'd0, 16'h0214, 1, 16'h0200);
      step("R10", 0, 16'h0000, 16'h0000, 0,0,0,0,1, 2'd2, 0, 3'd0, 16'h0000, 0, 16'h0000);
      step("R10", 1, 16'h0218, 16'h021c, 0,0,0,0,0, 2'd2, 0, 3'd0, 16'h0000, 0, 16'h0000);
      step("R6",  1, 16'h021c, 16'h0220, 0,0,0,1,0, 2'd1, 0, 3'd0, 16'h0000, 1, 16'h0214);
      step("R8",  1, 16'h0120, 16'h0124, 0,0,0,0,0, 2'd2, 1, 3'd4, 16'h0124, 1, 16'h0220);
      step("R6",  1, 16'h0224, 16'h0228, 0,0,0,1,0, 2'd1, 0, 3'd0, 16'h0000, 1, 16'h0124);
      step("R6",  1, 16'h0128, 16'h012c, 0,0,0,1,0, 2'd0, 0, 3'd0, 16'h0000, 1, 16'h0060);
      step("R7",  1, 16'h0064, 16'h0068, 0,0,0,1,0, 2'd1, 1, 3'd3, 16'h0064, 1, 16'h0118);
      step("R6",  1, 16'h0118, 16'h011c, 0,0,0,1,0, 2'd0, 0, 3'd0, 16'h0000, 1, 16'h0064);
      step("R5",  1, 16'h0070, 16'h0074, 1,1,1,1,0, 2'd1, 1, 3'd3, 16'h0070, 1, 16'h0118);
      step("R6",  1, 16'h011c, 16'h0120, 0,0,0,1,0, 2'd0, 0, 3'd0, 16'h0000, 1, 16'h0070);
      step("R5",  1, 16'h0074, 16'h0078, 1,1,0,0,0, 2'd1, 1, 3'd1, 16'h0074, 1, 16'h0108);
      step("R6",  1, 16'h010c, 16'h0110, 0,0,0,1,0, 2'd0, 0, 3'd0, 16'h0000, 1, 16'h0074);
      step("R9",  1, 16'h0078, 16'h007c, 1,0,0,0,1, 2'd1, 1, 3'd0, 16'h0078, 1, 16'h0100);
      step("R9",  1, 16'h0100, 16'h0104, 0,0,0,0,0, 2'd2, 1, 3'd4, 16'h0104, 1, 16'h0220);
      step("R6",  1, 16'h0220, 16'h0224, 0,0,0,1,0, 2'd1, 0, 3'd0, 16'h0000, 1, 16'h0104);
      step("R6",  1, 16'h0104, 16'h0108, 0,0,0,1,0, 2'd0, 0, 3'd0, 16'h0000, 1, 16'h0078);
      step("R9",  0, 16'h0000, 16'h0000, 0,0,0,0,1, 2'd0, 0, 3'd0, 16'h0000, 0, 16'h0000);
      step("R9",  0, 16'h0000, 16'h0000, 0,0,0,0,0, 2'd0, 0, 3'd0, 16'h0000, 0, 16'h0000);
      step("R8",  1, 16'h0080, 16'h0084, 0,0,0,0,0, 2'd1, 1, 3'd4, 16'h0084, 1, 16'h0120);
      step("R3",  1, 16'h0130, 16'h0134, 0,0,1,0,0, 2'd2, 1, 3'd3, 16'h0130, 1, 16'h0218);
      step("R11", 0, 16'h0000, 16'h0000, 0,0,0,0,0, 2'd2, 0, 3'd0, 16'h0000, 0, 16'h0000);
      @(negedge clk);
      instr_valid = 0; svc_req = 0; dbg_req = 0; unk_req = 0; ret_req = 0; hwm_req = 0;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule